// File: doc/BRIEF.md
# Rotating General Register File

This block holds 128 integer registers of 64 bits each and exposes them through two combinational read ports and one clocked write port. Callers always name registers by logical number. Logical numbers 0 to 31 are fixed and select the physical entry with the same number. Logical numbers 32 to 127 form a rotating window: a rotating base, kept inside the block, is added to the offset into the window modulo 96 before the storage is accessed. Software-pipelined loops use this so that one logical name reaches a new physical entry on every iteration, with no copy instructions.

A one-cycle step input advances the base by one and wraps from 95 back to 0. A clear input puts the base back to zero. Register 0 is hardwired to zero: it always reads as zero, and writes to it are dropped. Reads and a write to the same register in one cycle do not forward, so the read returns the value held before the write.

Top module: `rot_gpr_file`

## Requirements
- R1: A read of logical register 0 on either port returns 64'h0 in the same cycle, whatever was written before.
- R2: A write with `wr_reg` = 0 changes no register: a later read of every register returns what it returned before.
- R3: For logical numbers 1 to 31 the physical entry equals the logical number, whatever the rotating base is.
- R4: For a logical number n from 32 to 127 the physical entry is 32 + ((n − 32 + base) mod 96). A write uses the base in effect in its own cycle.
- R5: When `rot_step` is high at a clock edge and `rot_clear` is low, the base grows by one from the next cycle on. A value seen at logical n (n from 33 to 127) before the step is seen at logical n − 1 after it, and the value at logical 32 moves to logical 127.
- R6: The base wraps from 95 to 0, so 96 steps restore the original mapping.
- R7: When `rot_clear` is high at a clock edge the base is zero from the next cycle on. This holds even when `rot_step` is also high.
- R8: A synchronous reset sets the base to zero. Stored register values are kept across reset.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.
- R10: The two read ports are independent and each returns its register's value combinationally, in the cycle its index is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the rotating base |
| rd0_reg | input | 7 | Logical register number for read port 0 |
| rd0_val | output | 64 | Data from read port 0 |
| rd1_reg | input | 7 | Logical register number for read port 1 |
| rd1_val | output | 64 | Data from read port 1 |
| wr_en | input | 1 | Write enable |
| wr_reg | input | 7 | Logical register number to write |
| wr_val | input | 64 | Data to write |
| rot_step | input | 1 | Advance the rotating base by one |
| rot_clear | input | 1 | Return the rotating base to zero (wins over rot_step) |

## Verification
The bench targets the seam of the rotating window. After a single step, the value at logical 32 has to show up at logical 127; an off-by-one in the modulo would instead return the contents of a static register or a wrong window entry. It also runs a full 96-step lap and compares every register with its value before the lap, which catches a base that wraps at 127 or at a power of two. Other cases cover a write issued in the same cycle as a step, which must use the old base; a step and a clear together, where clear must win; a read that collides with a write, which must return the old data where a stray bypass would return the new; and writes to register 0, which must leave reads of zero unchanged.

// File: rtl/rgf_pkg.sv
package rgf_pkg;

    parameter int XLEN    = 64;
    parameter int NREG    = 128;
    parameter int NSTATIC = 32;

    localparam int NROT   = NREG - NSTATIC;
    localparam int IDX_W  = $clog2(NREG);
    localparam int BASE_W = $clog2(NROT);

    typedef logic [IDX_W-1:0]  ridx_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [XLEN-1:0]   word_t;

    // write request already translated to a physical entry
    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wr_req_t;

    // logical number -> physical entry under a given rotating base
    function automatic ridx_t to_phys(ridx_t lidx, base_t base);
        logic [IDX_W:0] off;
        if (lidx < ridx_t'(NSTATIC)) begin
            return lidx;
        end
        off = {1'b0, lidx} - (IDX_W+1)'(NSTATIC) + (IDX_W+1)'(base);
        if (off >= (IDX_W+1)'(NROT)) begin
            off = off - (IDX_W+1)'(NROT);
        end
        return ridx_t'(off + (IDX_W+1)'(NSTATIC));
    endfunction

endpackage

// File: rtl/rgf_base_ctr.sv
module rgf_base_ctr
    import rgf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  clear,
    output base_t base
);

    localparam base_t BASE_TOP = base_t'(NROT - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            base <= '0;
        end else if (step) begin
            base <= (base == BASE_TOP) ? '0 : base_t'(base + 1'b1);
        end
    end

    // R5
    step_advances_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && base != BASE_TOP) |=> base == base_t'($past(base) + 1'b1));

    // R6
    base_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && base == BASE_TOP) |=> base == '0);

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> base == '0);

    // R8
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> base == '0);

    // R6
    base_range_chk: assert property (@(posedge clk) disable iff (rst)
        base <= BASE_TOP);

    // R5
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(base));

endmodule

// File: rtl/rgf_rename.sv
module rgf_rename
    import rgf_pkg::*;
(
    input  ridx_t lidx,
    input  base_t base,
    output ridx_t pidx
);

    assign pidx = to_phys(lidx, base);

    // R4: rotating names never land in the static region, and the reverse
    always_comb begin
        window_kept_chk: assert ((lidx >= ridx_t'(NSTATIC)) == (pidx >= ridx_t'(NSTATIC)));
    end

endmodule

// File: rtl/rgf_storage.sv
module rgf_storage
    import rgf_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic                clk,
    input  wr_req_t             wr,
    input  ridx_t [NRD-1:0]     rd_idx,
    output word_t [NRD-1:0]     rd_data
);

    word_t mem [NREG];

    always_ff @(posedge clk) begin
        if (wr.en && wr.idx != '0) begin
            mem[wr.idx] <= wr.data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] == '0) ? '0 : mem[rd_idx[p]];
    end

endmodule

// File: rtl/rot_gpr_file.sv
module rot_gpr_file
    import rgf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  rd0_reg,
    output logic [63:0] rd0_val,
    input  logic [6:0]  rd1_reg,
    output logic [63:0] rd1_val,
    input  logic        wr_en,
    input  logic [6:0]  wr_reg,
    input  logic [63:0] wr_val,
    input  logic        rot_step,
    input  logic        rot_clear
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    base_t                base;
    ridx_t [NPORT-1:0]    lreg;
    ridx_t [NPORT-1:0]    preg;
    word_t [NRD-1:0]      rdata;
    wr_req_t              wreq;

    rgf_base_ctr u_base (
        .clk   (clk),
        .rst   (rst),
        .step  (rot_step),
        .clear (rot_clear),
        .base  (base)
    );

    assign lreg = {wr_reg, rd1_reg, rd0_reg};

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rgf_rename u_map (
            .lidx (lreg[g]),
            .base (base),
            .pidx (preg[g])
        );
    end

    always_comb begin
        wreq.en   = wr_en;
        wreq.idx  = preg[NPORT-1];
        wreq.data = wr_val;
    end

    rgf_storage #(.NRD(NRD)) u_store (
        .clk     (clk),
        .wr      (wreq),
        .rd_idx  (preg[NRD-1:0]),
        .rd_data (rdata)
    );

    assign rd0_val = rdata[0];
    assign rd1_val = rdata[1];

    // R1
    zero_port0_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_reg == '0) |-> rd0_val == '0);

    // R1
    zero_port1_chk: assert property (@(posedge clk) disable iff (rst)
        (rd1_reg == '0) |-> rd1_val == '0);

    // R9: with no write since last cycle, a repeated read is unchanged
    stable_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rot_step && !rot_clear) |=> (rd0_reg != $past(rd0_reg)) || $stable(rd0_val));

endmodule

// File: tb/rot_gpr_file_bench.sv
module rot_gpr_file_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  rd0_reg = '0;
    logic [63:0] rd0_val;
    logic [6:0]  rd1_reg = '0;
    logic [63:0] rd1_val;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_reg = '0;
    logic [63:0] wr_val = '0;
    logic        rot_step = 1'b0;
    logic        rot_clear = 1'b0;

    always #5 clk = ~clk;

    rot_gpr_file u_rot_gpr_file (
        .clk(clk), .rst(rst),
        .rd0_reg(rd0_reg), .rd0_val(rd0_val),
        .rd1_reg(rd1_reg), .rd1_val(rd1_val),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_val(wr_val),
        .rot_step(rot_step), .rot_clear(rot_clear)
    );

    typedef struct {
        int          ra;
        int          rb;
        logic [63:0] ea;
        logic [63:0] eb;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    event        sample_ev;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    // bench model: physical contents and rotating base, from the requirements
    logic [63:0] mdl [128];
    int          brrb = 0;

    function automatic int bphys(int n);
        if (n < 32) return n;
        return 32 + ((n - 32 + brrb) % 96);
    endfunction

    function automatic logic [63:0] mread(int n);
        if (n == 0) return 64'h0;
        return mdl[bphys(n)];
    endfunction

    function automatic logic [63:0] pat(int n, int salt);
        return {32'(salt) ^ 32'hC3A5_0000, 32'(n) * 32'h0001_0003};
    endfunction

    // driver: one cycle of stimulus, expected reads pushed to the scoreboard
    task automatic step(input bit we, input int wi, input logic [63:0] wd,
                        input bit rot, input bit clr, input int ra, input int rb,
                        input string tag, input bit chk);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_reg = 7'(wi); wr_val = wd;
        rot_step = rot; rot_clear = clr;
        rd0_reg = 7'(ra); rd1_reg = 7'(rb);
        if (chk) begin
            e.ra = ra; e.rb = rb; e.ea = mread(ra); e.eb = mread(rb); e.tag = tag;
            sb_q.push_back(e);
            #2;
            -> sample_ev;
        end
        @(posedge clk);
        if (we && wi != 0) mdl[bphys(wi)] = wd;
        if (clr) brrb = 0;
        else if (rot) brrb = (brrb + 1) % 96;
    endtask

    task automatic idle_rd(input int ra, input int rb, input string tag);
        step(1'b0, 0, 64'h0, 1'b0, 1'b0, ra, rb, tag, 1'b1);
    endtask

    task automatic rotate_n(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 0, 64'h0, 1'b1, 1'b0, 0, 0, "", 1'b0);
    endtask

    task automatic read_all(input string tag);
        for (int n = 0; n < 128; n += 2) idle_rd(n, n + 1, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rot_step = 1'b0; rot_clear = 1'b0;
        repeat (2) @(posedge clk);
        brrb = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // monitor: compares the design's read data with scoreboard items
    initial begin
        exp_t e;
        forever begin
            @(sample_ev);
            e = sb_q.pop_front();
            checks += 2;
            if (rd0_val !== e.ea) begin
                failures++;
                $display("FAIL %s port0 reg %0d: actual %h expected %h", e.tag, e.ra, rd0_val, e.ea);
            end
            if (rd1_val !== e.eb) begin
                failures++;
                $display("FAIL %s port1 reg %0d: actual %h expected %h", e.tag, e.rb, rd1_val, e.eb);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) mdl[i] = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R8: reset state, register 0 reads zero on both ports
        idle_rd(0, 0, "R1 reset state");

        // fill every register with base 0 (R4 mapping at base 0)
        for (int n = 1; n < 128; n++) step(1'b1, n, pat(n, 1), 1'b0, 1'b0, 0, 0, "", 1'b0);
        // R10: independent combinational read ports over the whole file
        read_all("R10 R4 readback base 0");

        // R2: write to register 0 is dropped
        step(1'b1, 0, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 1'b0, 0, 5, "R2 write r0", 1'b1);
        idle_rd(0, 1, "R2 r0 after write");
        read_all("R2 no entry disturbed");

        // R9: read during write returns old value, new value next cycle
        step(1'b1, 40, pat(40, 2), 1'b0, 1'b0, 40, 7, "R9 colliding read", 1'b1);
        idle_rd(40, 7, "R9 new value");
        step(1'b1, 9, pat(9, 2), 1'b0, 1'b0, 3, 9, "R9 static collide", 1'b1);
        idle_rd(9, 3, "R9 static new");

        // R5: one step; old logical 32 must appear at 127, 33 at 32
        rotate_n(1);
        idle_rd(127, 32, "R5 seam after one step");
        read_all("R5 window after one step");
        // R3: static names untouched by rotation
        for (int n = 1; n < 32; n += 2) idle_rd(n, n + 1, "R3 static under rotation");

        // R4: write with a step in the same cycle uses the old base
        step(1'b1, 50, pat(50, 3), 1'b1, 1'b0, 50, 51, "R4 write with step", 1'b1);
        step(1'b1, 127, pat(127, 3), 1'b0, 1'b0, 0, 0, "", 1'b0);
        read_all("R4 rotated writes");

        // R6: complete a 96-step lap from here and compare everything
        rotate_n(95);
        read_all("R6 full lap");

        // R7: clear together with step returns base to zero
        rotate_n(4);
        step(1'b0, 0, 64'h0, 1'b1, 1'b1, 0, 0, "", 1'b0);
        idle_rd(32, 127, "R7 clear beats step");
        read_all("R7 mapping after clear");

        // R8: reset returns base to zero and keeps contents
        rotate_n(7);
        idle_rd(32, 38, "R8 before reset");
        do_reset();
        read_all("R8 after reset");

        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule